// File: doc/BRIEF.md
# Fractional Clock-Enable Generator

This block derives two clock-enable strobes from one parent clock. Each strobe runs at a programmable fraction of the parent rate. A 5-bit field per channel selects a multiplier m = 32 - field, so m runs from 1 to 32. Each channel spreads m pulses evenly over a repeating 32-slot window. A fixed divide-by-two stage passes every second pulse, so the enable rate is parent * m / 32 / 2.

Software writes both fields into a frequency-control register. The fields have no effect on the outputs until software sets the commit bit in a separate commit/status register. A three-state commit machine takes the request from `ST_IDLE` to `ST_ARMED` on a commit write. It goes from `ST_ARMED` to `ST_SETTLE` at the next window boundary, and it copies both pending fields into the channels in that same cycle. It goes from `ST_SETTLE` back to `ST_IDLE` one full window later. The commit bit reads as 1 in every state except `ST_IDLE`, and software polls it as the busy flag.

Top module: `frac_clk_enable_gen`

## Requirements
- R1: After reset, `busy` is 0, both enables are 0, both pending fields read 0, and both channels run with multiplier 32.
- R2: Address 0 holds the channel-0 field in bits 12:8 and the channel-1 field in bits 4:0, and all its other bits read 0. Address 1 reads the busy flag in bit 31 and reads 0 in every other bit. The read data is combinational on `bus_addr`.
- R3: An enable is never high on two consecutive cycles. While its multiplier m = 32 - field is stable, a channel asserts its enable exactly m times in any 64 consecutive cycles.
- R4: Field value 0 gives the fastest rate: one enable every second cycle. Field value 31 gives the slowest rate: one enable per 64 cycles.
- R5: A write to address 1 with bit 31 set, made while `busy` is 0, raises `busy` in the next cycle. A write to address 1 with bit 31 clear has no effect.
- R6: The pending fields are applied at the end of the first 32-cycle window after the commit write. In that cycle both accumulators and both divide-by-two phases restart from 0. `busy` falls exactly 32 cycles after the fields are applied, so a commit write made at window slot s keeps `busy` high for 63 - s cycles, or 64 cycles when s is 31.
- R7: While `busy` is 1, writes to address 0 and further commit writes are ignored. The read-back value and the busy duration do not change.
- R8: Writing address 0 without a commit leaves both enable patterns unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 1 | Register select: 0 = frequency control, 1 = commit/status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| busy | output | 1 | Commit in progress (mirrors the commit bit) |
| ena_out | output | 2 | Clock enables: bit 0 = channel 0, bit 1 = channel 1 |

## Verification
The hardest cases to reach are commits whose window position is known exactly. The busy length, and the cycle in which the new pattern starts, both depend on the slot at which the commit lands. The bench waits until its own model slot counter reaches a chosen value, slot 10 or the boundary slot 31, and only then issues the commit. During the busy period it also issues a field write and a second commit. It then checks the read-back value and the busy length against the slot arithmetic. A cycle-level reference model is compared on every clock as well.

// File: rtl/fpsd_pkg.sv
package fpsd_pkg;

    localparam int unsigned NUM_CH = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SETTLE = 2'd2
    } commit_state_t;

    // Field placement inside the frequency-control word.
    function automatic int unsigned field_lsb(input int unsigned ch);
        return (ch == 0) ? 8 : 0;
    endfunction

endpackage

// File: rtl/fpsd_window.sv
module fpsd_window #(
    parameter int unsigned FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [FIELD_W-1:0] slot,
    output logic               window_end
);
    logic [FIELD_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign slot       = slot_q;
    assign window_end = &slot_q;
endmodule

// File: rtl/fpsd_commit_fsm.sv
module fpsd_commit_fsm
    import fpsd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick_req,
    input  logic          window_end,
    output commit_state_t state,
    output logic          busy,
    output logic          load_now
);
    commit_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (kick_req)   state_d = ST_ARMED;
            ST_ARMED:  if (window_end) state_d = ST_SETTLE;
            ST_SETTLE: if (window_end) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = 1'b1;
        load_now = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_ARMED:  load_now = window_end;
            ST_SETTLE: busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/fpsd_channel.sv
module fpsd_channel #(
    parameter int unsigned FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_now,
    input  logic [FIELD_W-1:0] new_field,
    output logic               ena
);
    localparam logic [FIELD_W:0] STEPS = (FIELD_W+1)'(1) << FIELD_W;

    logic [FIELD_W:0]   mult_q;
    logic [FIELD_W-1:0] acc_q;
    logic               phase_q;
    logic               ena_q;
    logic [FIELD_W:0]   sum;
    logic               carry;

    assign sum   = {1'b0, acc_q} + mult_q;
    assign carry = sum[FIELD_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mult_q  <= STEPS;
            acc_q   <= '0;
            phase_q <= 1'b0;
            ena_q   <= 1'b0;
        end else if (load_now) begin
            mult_q  <= STEPS - {1'b0, new_field};
            acc_q   <= '0;
            phase_q <= 1'b0;
            ena_q   <= 1'b0;
        end else begin
            acc_q   <= sum[FIELD_W-1:0];
            ena_q   <= carry & phase_q;
            if (carry) begin
                phase_q <= ~phase_q;
            end
        end
    end

    assign ena = ena_q;
endmodule

// File: rtl/frac_clk_enable_gen.sv
module frac_clk_enable_gen
    import fpsd_pkg::*;
#(
    parameter int unsigned FIELD_W  = 5,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned KICK_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic [NUM_CH-1:0] ena_out
);
    localparam int unsigned PEND_W = NUM_CH * FIELD_W;

    logic [FIELD_W-1:0] pend_q [NUM_CH];
    logic [PEND_W-1:0]  pend_flat;
    logic [FIELD_W-1:0] slot_w;
    logic               window_end_w;
    logic               load_w;
    logic               busy_w;
    logic               kick_req;
    logic               field_wr;
    commit_state_t      state_w;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign field_wr = bus_wr && !bus_addr && !busy_w;
    assign kick_req = bus_wr &&  bus_addr && bus_wdata[KICK_BIT];

    fpsd_window #(.FIELD_W(FIELD_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot_w),
        .window_end (window_end_w)
    );

    fpsd_commit_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_req   (kick_req),
        .window_end (window_end_w),
        .state      (state_w),
        .busy       (busy_w),
        .load_now   (load_w)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam int unsigned LSB = field_lsb(ch);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[ch] <= '0;
            end else if (field_wr) begin
                pend_q[ch] <= bus_wdata[LSB +: FIELD_W];
            end
        end

        assign pend_flat[ch*FIELD_W +: FIELD_W] = pend_q[ch];

        fpsd_channel #(.FIELD_W(FIELD_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_now  (load_w),
            .new_field (pend_q[ch]),
            .ena       (ena_out[ch])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr) begin
            bus_rdata[KICK_BIT] = busy_w;
        end else begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                bus_rdata[field_lsb(ch) +: FIELD_W] = pend_q[ch];
            end
        end
    end

    assign busy = busy_w;
endmodule

// File: rtl/fpsd_checker.sv
module fpsd_checker #(
    parameter int unsigned FIELD_W = 5,
    parameter int unsigned PEND_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               busy,
    input logic [1:0]         ena_out,
    input logic [FIELD_W-1:0] slot_w,
    input logic               load_w,
    input logic [PEND_W-1:0]  pend_flat
);
    // R5: commit write while idle raises busy next cycle
    p_kick_raises_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_wr && bus_addr && bus_wdata[31]) |=> busy);

    // R6: fields are applied only at a window boundary while a commit is pending
    p_apply_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |-> (busy && (&slot_w)));

    // R6: busy only falls right after a window boundary
    p_busy_falls_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (&$past(slot_w)));

    // R7: pending fields frozen while busy
    p_fields_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pend_flat));

    // R3: no enable on two consecutive cycles
    p_no_back_to_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ena_out) |=> ((ena_out & $past(ena_out)) == 2'b00));
endmodule

bind frac_clk_enable_gen fpsd_checker #(.FIELD_W(FIELD_W), .PEND_W(PEND_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .ena_out   (ena_out),
    .slot_w    (slot_w),
    .load_w    (load_w),
    .pend_flat (pend_flat)
);

// File: tb/frac_clk_enable_gen_bench.sv
`timescale 1ns/1ps
module frac_clk_enable_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        busy;
    logic [1:0]  ena_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    frac_clk_enable_gen u_frac_clk_enable_gen (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .ena_out(ena_out)
    );

    // Behavioural reference model
    int m_slot, m_state;
    int m_pend [2];
    int m_mult [2];
    int m_acc  [2];
    int m_ph   [2];
    int m_ena  [2];
    int m_ld, m_kick, m_sum;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_slot = 0; m_state = 0;
            for (int c = 0; c < 2; c++) begin
                m_pend[c] = 0; m_mult[c] = 32; m_acc[c] = 0; m_ph[c] = 0; m_ena[c] = 0;
            end
        end else begin
            m_ld   = (m_state == 1 && m_slot == 31);
            m_kick = (bus_wr && bus_addr && bus_wdata[31] && m_state == 0);
            for (int c = 0; c < 2; c++) begin
                if (m_ld) begin
                    m_mult[c] = 32 - m_pend[c]; m_acc[c] = 0; m_ph[c] = 0; m_ena[c] = 0;
                end else begin
                    m_sum = m_acc[c] + m_mult[c];
                    m_ena[c] = (m_sum >= 32 && m_ph[c] == 1);
                    if (m_sum >= 32) m_ph[c] = 1 - m_ph[c];
                    m_acc[c] = m_sum % 32;
                end
            end
            if (bus_wr && !bus_addr && m_state == 0) begin
                m_pend[0] = (bus_wdata >> 8) & 31;
                m_pend[1] = bus_wdata & 31;
            end
            case (m_state)
                0: if (m_kick) m_state = 1;
                1: if (m_slot == 31) m_state = 2;
                default: if (m_slot == 31) m_state = 0;
            endcase
            m_slot = (m_slot + 1) % 32;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ena_out[0] == m_ena[0][0], "R3 channel 0 enable pattern", ena_out[0], m_ena[0]);
            chk(ena_out[1] == m_ena[1][0], "R3 channel 1 enable pattern", ena_out[1], m_ena[1]);
            chk(busy == (m_state != 0), "R6 busy per cycle", busy, m_state != 0);
        end
    end

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_check(input logic a, input logic [31:0] exp, input string what);
        @(negedge clk); bus_wr = 1'b0; bus_addr = a;
        #2 chk(bus_rdata == exp, what, bus_rdata, exp);
    endtask

    task automatic count_ena(input int exp0, input int exp1, input string what);
        int c0 = 0;
        int c1 = 0;
        repeat (64) begin
            @(negedge clk); c0 += ena_out[0]; c1 += ena_out[1];
        end
        chk(c0 == exp0, {what, " ch0"}, c0, exp0);
        chk(c1 == exp1, {what, " ch1"}, c1, exp1);
    endtask

    // Commit at a chosen slot; poke the port while busy; time the busy period.
    task automatic commit_at(input int want_slot, input logic [31:0] expect_rd);
        int s;
        int cnt = 0;
        int expd;
        do @(negedge clk); while (m_slot != want_slot);
        s = m_slot;
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h8000_0000;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        chk(busy == 1'b1, "R5 busy after commit", busy, 1);
        while (busy && cnt < 200) begin
            cnt++;
            if (cnt == 3) begin bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 32'h0000_0000; end
            else if (cnt == 5) begin bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h8000_0000; end
            else begin bus_wr = 1'b0; bus_wdata = '0; end
            @(negedge clk);
        end
        bus_wr = 1'b0;
        expd = (s == 31) ? 64 : 63 - s;
        chk(cnt == expd, "R6 R7 busy duration", cnt, expd);
        rd_check(1'b0, expect_rd, "R7 field write ignored while busy");
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #2;
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(ena_out == 2'b00, "R1 enables after reset", ena_out, 0);
        rd_check(1'b0, 32'h0, "R1 fields after reset");
        rd_check(1'b1, 32'h0, "R1 R2 status after reset");
        count_ena(32, 32, "R1 R4 default multiplier 32");

        // R2 layout, R8 no effect without commit
        wr(1'b0, 32'hA5A5_00E0 | (32'd5 << 8) | 32'd31);
        rd_check(1'b0, 32'h0000_051F, "R2 field read-back");
        count_ena(32, 32, "R8 pattern unchanged before commit");

        // R5 commit with bit 31 clear
        wr(1'b1, 32'h7FFF_FFFF);
        chk(busy == 1'b0, "R5 commit bit clear has no effect", busy, 0);

        // R6/R7 commit mid-window
        commit_at(10, 32'h0000_051F);
        rd_check(1'b1, 32'h0, "R2 status idle after commit");
        count_ena(27, 1, "R3 R4 multipliers 27 and 1");

        // Second setting, commit at the boundary slot
        wr(1'b0, (32'd16 << 8) | 32'd0);
        commit_at(31, 32'h0000_1000);
        count_ena(16, 32, "R3 multipliers 16 and 32");

        // Extreme: channel 0 slowest, channel 1 mid
        wr(1'b0, (32'd31 << 8) | 32'd20);
        commit_at(0, 32'h0000_1F14);
        count_ena(1, 12, "R4 R3 multipliers 1 and 12");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule